// File: doc/BRIEF.md
# Zig-zag LDPC frame encoder

This block turns one frame of information bits into a systematic codeword of a low-density parity-check code with a zig-zag structure. Each frame starts with a command that gives the frame length in bytes, the size of the parity-check group, and the step and start offset of the interleaver. The block stores the frame's bits as they arrive and then sends them back out unchanged. After that it sends the parity bits.

The parity path works in four stages. A two-state feed-forward code XORs each stored bit with the bit before it, and the first bit wraps around to take the frame's final bit as its predecessor. Every resulting hidden bit is used twice. The doubled sequence is read in an order set by an arithmetic interleaver. Each group of J interleaved bits is folded into one check bit, and a running accumulator turns the check bits into the parity stream. The code rate is J/(J+2) and is chosen only through J. Commands with an illegal configuration are refused with a one-cycle error pulse.

Top module: `zz_ldpc_enc`

## Requirements
- R1: Reset state. While reset is held and in the cycle after it is released, cmd_ready is 1, and in_ready, out_valid and cfg_err are 0.
- R2: Command refusal. The block refuses a command in any of these cases: the byte count is below 3 or above 1000; jsel is above 4; 16*bytes is not a multiple of J; step is 0; step is not below 16*bytes; offset is not below 16*bytes. A refused command raises cfg_err for exactly the one cycle after the command. No frame starts: in_ready stays 0 and cmd_ready stays 1.
- R3: For an accepted command, exactly K = 8*bytes input bits are taken, one per cycle in which in_valid and in_ready are both 1. Input bit i is information bit b[i]. After the last of these bits, in_ready falls to 0.
- R4: The first K output bits are b[0]..b[K-1], in input order.
- R5: Hidden bit c[i] = b[i] XOR b[i-1] for i ≥ 1. The hidden sequence tail-bites, so c[0] = b[0] XOR b[K-1].
- R6: The doubled stream d has d[a] = c[a>>1] for a in 0..2K-1. Interleaved position n (0 ≤ n < 2K) carries d[(n*step + offset) mod 2K].
- R7: jsel values 0, 1, 2, 3, 4 select J = 2, 4, 8, 16, 32. Check bit e[v] is the XOR of interleaved positions v*J through v*J+J-1. There are V = 2K/J check bits.
- R8: Parity p[v] = p[v-1] XOR e[v], with p[-1] = 0 and no termination. The V parity bits follow the systematic bits in index order, and nothing else is emitted.
- R9: out_last is 1 only while the final parity bit is offered. After that bit is taken, cmd_ready returns to 1.
- R10: While out_valid is 1 and out_ready is 0, out_valid, out_bit and out_last hold their values into the next cycle. in_ready and out_valid are never 1 together.
- R11: Each frame uses the length, J, step and offset of its own command, independent of earlier frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Frame command offered |
| cmd_ready | output | 1 | Block idle and able to take a command |
| cmd_bytes | input | 10 | Frame length in bytes |
| cmd_jsel | input | 3 | Group size select, J = 2^(jsel+1) |
| cmd_step | input | 14 | Interleaver step, coprime with 2K |
| cmd_offset | input | 14 | Interleaver start offset |
| cfg_err | output | 1 | One-cycle pulse for a refused command |
| in_valid | input | 1 | Information bit offered |
| in_ready | output | 1 | Block is taking information bits |
| in_bit | input | 1 | Information bit |
| out_valid | output | 1 | Codeword bit offered |
| out_ready | input | 1 | Sink takes the codeword bit |
| out_bit | output | 1 | Codeword bit |
| out_last | output | 1 | Marks the final parity bit of the frame |

## Verification
The hardest cases to reach are the wrap-arounds inside the parity path. The tail-biting link between the last and first information bits only shows up when one of those two bits differs from the rest of the frame. The interleaver subtracts 2K only when the running address passes the end of the doubled stream. To reach both, the stimulus uses frames with a single set bit at the first or the last position, offsets just below 2K, and steps that cross the end many times. The sink drops out_ready at random, so parity bits are also stalled in the middle of a group sequence. A largest-size frame exercises the full buffer and address widths.

// File: rtl/zz_enc_pkg.sv
package zz_enc_pkg;

    // largest group size exponent: J = 2^JLOG_MAX
    localparam int unsigned JLOG_MAX = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SYS,
        ST_PACC,
        ST_POUT
    } enc_state_e;

    // group size select to log2(J)
    function automatic logic [2:0] jsel_to_log(input logic [2:0] jsel);
        return jsel + 3'd1;
    endfunction

    function automatic logic jsel_legal(input logic [2:0] jsel);
        return jsel <= 3'(JLOG_MAX - 1);
    endfunction

endpackage

// File: rtl/zz_frame_buf.sv
module zz_frame_buf #(
    parameter int MAX_BYTES = 1000,
    parameter int KLW       = 13
) (
    input  logic           clk,
    input  logic           wr_en,
    input  logic [KLW-1:0] wr_idx,
    input  logic           wr_bit,
    input  logic [KLW-1:0] sys_idx,
    input  logic [KLW-1:0] hid_idx,
    input  logic [KLW-1:0] k_len,
    output logic           sys_bit,
    output logic           hid_bit
);
    localparam int BAW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic [7:0]     mem [MAX_BYTES];
    logic [KLW-1:0] prev_idx;

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[BAW'(wr_idx >> 3)][wr_idx[2:0]] <= wr_bit;
    end

    // tail-biting predecessor: index 0 pairs with the last stored bit
    assign prev_idx = (hid_idx == '0) ? k_len - 1'b1 : hid_idx - 1'b1;

    assign sys_bit = mem[BAW'(sys_idx >> 3)][sys_idx[2:0]];
    assign hid_bit = mem[BAW'(hid_idx >> 3)][hid_idx[2:0]]
                   ^ mem[BAW'(prev_idx >> 3)][prev_idx[2:0]];

endmodule

// File: rtl/zz_ilv_addr.sv
module zz_ilv_addr #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    input  logic [AW-1:0] start_addr,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] span,
    output logic [AW-1:0] addr
);
    logic [AW:0] sum;
    logic [AW:0] nxt;
    logic        active;

    // running (n*step + offset) mod span without a multiplier
    assign sum = {1'b0, addr} + {1'b0, step};
    assign nxt = (sum >= {1'b0, span}) ? sum - {1'b0, span} : sum;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr   <= '0;
            active <= 1'b0;
        end else if (load) begin
            addr   <= start_addr;
            active <= 1'b1;
        end else if (adv) begin
            addr   <= nxt[AW-1:0];
        end
    end

    // R6: the address never leaves the doubled stream
    a_r6_addr_in_span: assert property (@(posedge clk) disable iff (rst)
        active |-> (addr < span));

endmodule

// File: rtl/zz_par_acc.sv
module zz_par_acc (
    input  logic clk,
    input  logic rst,
    input  logic init,
    input  logic en,
    input  logic close,
    input  logic d_in,
    output logic parity
);
    logic spc;

    always_ff @(posedge clk) begin
        if (rst || init) begin
            spc    <= 1'b0;
            parity <= 1'b0;
        end else if (en) begin
            if (close) begin
                parity <= parity ^ spc ^ d_in;
                spc    <= 1'b0;
            end else begin
                spc    <= spc ^ d_in;
            end
        end
    end

    // R8: the accumulator moves only when a group closes
    a_r8_parity_holds: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(init) && !$past(en && close)) |-> $stable(parity));

endmodule

// File: rtl/zz_ldpc_enc.sv
module zz_ldpc_enc
    import zz_enc_pkg::*;
#(
    parameter int MAX_BYTES = 1000,
    parameter int MIN_BYTES = 3,
    localparam int BW  = $clog2(MAX_BYTES + 1),
    localparam int KLW = $clog2(8 * MAX_BYTES + 1),
    localparam int AW  = $clog2(16 * MAX_BYTES + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    output logic          cmd_ready,
    input  logic [BW-1:0] cmd_bytes,
    input  logic [2:0]    cmd_jsel,
    input  logic [AW-1:0] cmd_step,
    input  logic [AW-1:0] cmd_offset,
    output logic          cfg_err,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic          in_bit,
    output logic          out_valid,
    input  logic          out_ready,
    output logic          out_bit,
    output logic          out_last
);
    enc_state_e          st;
    logic [KLW-1:0]      k_len;
    logic [AW-1:0]       n2;
    logic [AW-1:0]       v_len;
    logic [AW-1:0]       step_q;
    logic [2:0]          jlog_q;
    logic [KLW-1:0]      cnt;
    logic [AW-1:0]       vcnt;
    logic [JLOG_MAX-1:0] jcnt;

    // command legality
    logic [AW:0]         n2_cmd;
    logic [2:0]          jlog_cmd;
    logic [JLOG_MAX-1:0] jmask_cmd;
    logic                div_ok;
    logic                cmd_ok;
    logic                cmd_fire;
    logic                frame_go;

    assign n2_cmd    = (AW + 1)'(cmd_bytes) << 4;
    assign jlog_cmd  = jsel_to_log(cmd_jsel);
    assign jmask_cmd = JLOG_MAX'((32'd1 << jlog_cmd) - 32'd1);
    assign div_ok    = (n2_cmd[JLOG_MAX-1:0] & jmask_cmd) == '0;
    assign cmd_ok    = (cmd_bytes >= BW'(MIN_BYTES)) && (cmd_bytes <= BW'(MAX_BYTES))
                     && jsel_legal(cmd_jsel) && div_ok && (cmd_step != '0)
                     && ({1'b0, cmd_step} < n2_cmd) && ({1'b0, cmd_offset} < n2_cmd);
    assign cmd_fire  = (st == ST_IDLE) && cmd_valid;
    assign frame_go  = cmd_fire && cmd_ok;

    // sequencing
    logic k_last, j_last, v_last;
    assign k_last = cnt == k_len - 1'b1;
    assign j_last = jcnt == JLOG_MAX'((32'd1 << jlog_q) - 32'd1);
    assign v_last = vcnt == v_len - 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            cfg_err <= 1'b0;
            k_len   <= '0;
            n2      <= '0;
            v_len   <= '0;
            step_q  <= '0;
            jlog_q  <= 3'd1;
            cnt     <= '0;
            vcnt    <= '0;
            jcnt    <= '0;
        end else begin
            cfg_err <= cmd_fire && !cmd_ok;
            unique case (st)
                ST_IDLE: if (frame_go) begin
                    k_len  <= KLW'(cmd_bytes) << 3;
                    n2     <= n2_cmd[AW-1:0];
                    v_len  <= AW'(n2_cmd >> jlog_cmd);
                    step_q <= cmd_step;
                    jlog_q <= jlog_cmd;
                    cnt    <= '0;
                    st     <= ST_LOAD;
                end
                ST_LOAD: if (in_valid) begin
                    cnt <= k_last ? '0 : cnt + 1'b1;
                    if (k_last) st <= ST_SYS;
                end
                ST_SYS: if (out_ready) begin
                    cnt <= k_last ? '0 : cnt + 1'b1;
                    if (k_last) begin
                        st   <= ST_PACC;
                        jcnt <= '0;
                        vcnt <= '0;
                    end
                end
                ST_PACC: begin
                    jcnt <= jcnt + 1'b1;
                    if (j_last) st <= ST_POUT;
                end
                ST_POUT: if (out_ready) begin
                    if (v_last) begin
                        st <= ST_IDLE;
                    end else begin
                        vcnt <= vcnt + 1'b1;
                        jcnt <= '0;
                        st   <= ST_PACC;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // datapath
    logic [AW-1:0] ilv_addr;
    logic          sys_bit;
    logic          hid_bit;
    logic          parity;

    zz_frame_buf #(.MAX_BYTES(MAX_BYTES), .KLW(KLW)) u_buf (
        .clk     (clk),
        .wr_en   ((st == ST_LOAD) && in_valid),
        .wr_idx  (cnt),
        .wr_bit  (in_bit),
        .sys_idx (cnt),
        .hid_idx (KLW'(ilv_addr >> 1)),
        .k_len   (k_len),
        .sys_bit (sys_bit),
        .hid_bit (hid_bit)
    );

    zz_ilv_addr #(.AW(AW)) u_ilv (
        .clk        (clk),
        .rst        (rst),
        .load       (frame_go),
        .adv        (st == ST_PACC),
        .start_addr (cmd_offset),
        .step       (step_q),
        .span       (n2),
        .addr       (ilv_addr)
    );

    zz_par_acc u_acc (
        .clk    (clk),
        .rst    (rst),
        .init   (frame_go),
        .en     (st == ST_PACC),
        .close  (j_last),
        .d_in   (hid_bit),
        .parity (parity)
    );

    assign cmd_ready = st == ST_IDLE;
    assign in_ready  = st == ST_LOAD;
    assign out_valid = (st == ST_SYS) || (st == ST_POUT);
    assign out_bit   = (st == ST_SYS) ? sys_bit : parity;
    assign out_last  = (st == ST_POUT) && v_last;

    // R10: input and output phases never overlap
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    // R10: a stalled output holds
    a_r10_hold_stall: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_valid && !out_ready))
        |-> (out_valid && $stable(out_bit) && $stable(out_last)));

    // R2: an error pulse follows a command taken while idle
    a_r2_err_after_cmd: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (!$past(rst) && $past(cmd_valid && cmd_ready)));

    // R2: a refused command starts no frame
    a_r2_err_stays_idle: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> (cmd_ready && !in_ready));

    // R9: the end marker only rides on an offered bit
    a_r9_last_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    // R9: taking the end marker returns the block to idle
    a_r9_idle_after_last: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(out_last && out_ready)) |-> cmd_ready);

endmodule

// File: tb/zz_ldpc_enc_test.sv
`timescale 1ns/1ps
module zz_ldpc_enc_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [9:0]  cmd_bytes = '0;
    logic [2:0]  cmd_jsel = '0;
    logic [13:0] cmd_step = '0;
    logic [13:0] cmd_offset = '0;
    logic        cfg_err;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic        in_bit = 1'b0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic        out_bit;
    logic        out_last;

    always #2.5 clk = ~clk;

    zz_ldpc_enc uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_bytes(cmd_bytes),
        .cmd_jsel(cmd_jsel), .cmd_step(cmd_step), .cmd_offset(cmd_offset),
        .cfg_err(cfg_err),
        .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
        .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
        .out_last(out_last)
    );

    int tests = 0;
    int fails = 0;
    bit b_arr [0:7999];
    bit c_arr [0:7999];
    logic [1:0] exp_q [$];   // {last, bit}
    bit last_seen = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // monitor: random sink, compares each transfer with the scoreboard
    initial begin
        bit stall_prev = 0;
        bit stall_bit = 0;
        bit stall_last = 0;
        logic [1:0] item;
        wait (rst == 1'b0);
        forever begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            #1;
            if (stall_prev)
                chk(out_valid && out_bit == stall_bit && out_last == stall_last,
                    "R10 stalled output held", int'(out_bit), int'(stall_bit));
            stall_prev = out_valid && !out_ready;
            stall_bit  = out_bit;
            stall_last = out_last;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 extra output bit", 1, 0);
                end else begin
                    item = exp_q.pop_front();
                    chk(out_bit == item[0], "R4 R5 R6 R7 R8 codeword bit",
                        int'(out_bit), int'(item[0]));
                    chk(out_last == item[1], "R9 out_last", int'(out_last), int'(item[1]));
                    if (out_last) last_seen = 1;
                end
            end
        end
    end

    task automatic send_cmd(input int nbytes, input int jsel, input int step, input int off);
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_bytes  = 10'(nbytes);
        cmd_jsel   = 3'(jsel);
        cmd_step   = 14'(step);
        cmd_offset = 14'(off);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic reject(input int nbytes, input int jsel, input int step, input int off);
        send_cmd(nbytes, jsel, step, off);
        #1;
        chk(cfg_err == 1'b1, "R2 refusal pulse", int'(cfg_err), 1);
        chk(in_ready == 1'b0, "R2 no frame after refusal", int'(in_ready), 0);
        @(negedge clk);
        #1;
        chk(cfg_err == 1'b0, "R2 pulse one cycle", int'(cfg_err), 0);
        chk(cmd_ready == 1'b1 && in_ready == 1'b0, "R2 stays idle", int'(cmd_ready), 1);
    endtask

    // pattern: 0 zeros, 1 ones, 2 single one at last bit, 3 random, 4 single one at bit 0
    task automatic run_frame(input int nbytes, input int jsel, input int step,
                             input int off, input int pattern);
        int k = nbytes * 8;
        int n2 = nbytes * 16;
        int jj = 1 << (jsel + 1);
        bit e = 0;
        bit p = 0;
        int npar = 0;
        int i = 0;
        for (int x = 0; x < k; x++) begin
            case (pattern)
                0: b_arr[x] = 0;
                1: b_arr[x] = 1;
                2: b_arr[x] = (x == k - 1);
                4: b_arr[x] = (x == 0);
                default: b_arr[x] = 1'($urandom);
            endcase
        end
        for (int x = 0; x < k; x++)
            c_arr[x] = b_arr[x] ^ b_arr[(x + k - 1) % k];
        for (int x = 0; x < k; x++) exp_q.push_back({1'b0, b_arr[x]});
        for (int n = 0; n < n2; n++) begin
            longint a = (longint'(n) * step + off) % n2;
            e ^= c_arr[a >> 1];
            if ((n % jj) == jj - 1) begin
                p ^= e;
                e = 0;
                npar++;
                exp_q.push_back({(npar == n2 / jj) ? 1'b1 : 1'b0, p});
            end
        end
        last_seen = 0;
        send_cmd(nbytes, jsel, step, off);
        #1;
        chk(in_ready == 1'b1 && cfg_err == 1'b0, "R3 frame accepted", int'(in_ready), 1);
        while (i < k) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            in_bit   = b_arr[i];
            #1;
            if (in_valid && in_ready) i++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R3 input closes after K bits", int'(in_ready), 0);
        while (!(exp_q.size() == 0 && cmd_ready)) begin
            @(negedge clk);
            #2;
        end
        chk(last_seen, "R9 R11 frame ended with marker", int'(last_seen), 1);
        chk(npar == k * 2 / jj, "R7 parity count", npar, k * 2 / jj);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        #1;
        chk(cmd_ready == 1 && in_ready == 0 && out_valid == 0 && cfg_err == 0,
            "R1 state in reset", int'(cmd_ready), 1);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(cmd_ready == 1 && in_ready == 0 && out_valid == 0 && cfg_err == 0,
            "R1 state after reset", int'(out_valid), 0);

        run_frame(3, 0, 1, 0, 3);        // R6 identity order, J=2
        run_frame(3, 1, 5, 7, 2);        // R5 tail-bit link, J=4
        run_frame(4, 4, 13, 3, 4);       // R7 J=32 on even byte count
        run_frame(5, 2, 7, 79, 1);       // R6 offset at end of span
        run_frame(6, 3, 5, 95, 0);       // all zero frame, J=16
        run_frame(20, 1, 37, 100, 3);    // R11 new size and step

        reject(2, 0, 1, 0);              // R2 too short
        reject(1001, 0, 1, 0);           // R2 too long
        reject(5, 4, 7, 0);              // R2 J=32 does not divide 80
        reject(4, 5, 13, 0);             // R2 illegal select
        reject(3, 0, 0, 0);              // R2 zero step
        reject(3, 0, 48, 0);             // R2 step at span
        reject(3, 0, 5, 48);             // R2 offset at span

        run_frame(3, 0, 11, 47, 3);      // R11 frame after refusals
        run_frame(1000, 3, 3, 15999, 3); // R3 largest frame
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R11 watchdog act=hung exp=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule